// File: doc/BRIEF.md
# One-Time-Programmable Word Programmer with Selective Retry

This block writes one 64-bit data word into a fuse-type memory array in which a cell can only change from 0 to 1. A start pulse launches an attempt. The block latches the word address, the two 32-bit data halves and a pulse-width count. It then drives a programming pulse onto each bit that must become 1, one bit at a time. After the last pulse it reads the location back once and compares the result with the requested data. The set of bits that disagree is kept as a failure record.

A later start with the retry flag raised pulses only the recorded failed bits, which lets software repeat marginal cells without stressing good ones. The mismatch count is graded: a single failed bit is reported as correctable, because the array's correction code can mask it, and two or more are reported as uncorrectable. A data word of all zeros skips the array entirely and raises a zero-word flag. The array itself is outside the block. It is reached through a bit-serial pulse port and a whole-word read port.

Top module: `otp_word_prog`

## Requirements
- R1: When `start_i` is high while `ready_o` is 1, the attempt is accepted and `ready_o` is 0 from the next cycle. The exception is a retry with no earlier attempt (R9). The same `start_i` launches first attempts and retries. An accepted start clears all three result flags.
- R2: A first attempt (`retry_i`=0) pulses every bit that is 1 in the 64-bit data, one at a time, in ascending bit order. Bits 31:0 come from `data_lo_i` and bits 63:32 from `data_hi_i`. `mem_bit_o` carries the bit index and `mem_addr_o` carries the latched 13-bit address.
- R3: A retry (`retry_i`=1) pulses only the bits that are both 1 in the newly supplied data and marked failed by the previous attempt. If no such bit exists, no pulse is issued.
- R4: A first attempt with all-zero data issues no pulse and no read. When `ready_o` returns to 1, `zero_o`=1 and `corr_o`=`uncorr_o`=0.
- R5: The failure record is the data XOR the read-back word. Exactly one set bit gives `corr_o`=1 and `uncorr_o`=0. Two or more give `uncorr_o`=1 and `corr_o`=0. None gives both flags 0. At most one of `zero_o`, `corr_o` and `uncorr_o` is ever 1.
- R6: `ready_o` is 0 from acceptance until the result flags are valid, and 1 otherwise. `mem_pgm_o` and `mem_rd_o` are only high while `ready_o` is 0.
- R7: Every pulse keeps `mem_pgm_o` high for exactly `pulse_cnt_i`+1 consecutive cycles, with `mem_bit_o` and `mem_addr_o` steady throughout. The count is latched at acceptance.
- R8: After the last pulse of an attempt (or at once when none are due), `mem_rd_o` is high for exactly one cycle. The block grades the word returned on `mem_rdata_i` in the following cycle, and `ready_o` rises the cycle after that. Read data is required one cycle after the strobe.
- R9: A start with `retry_i`=1 before any attempt has completed since reset is ignored. `ready_o` stays 1, no pulse is issued and the flags stay unchanged.
- R10: After reset `ready_o`=1, all result flags are 0, and `mem_pgm_o`=`mem_rd_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | Physical word location to program |
| data_lo_i | input | 32 | Data bits 31:0 |
| data_hi_i | input | 32 | Data bits 63:32 |
| start_i | input | 1 | One-cycle launch request |
| retry_i | input | 1 | 1 = pulse only previously failed bits |
| pulse_cnt_i | input | 8 | Pulse length in cycles minus one |
| ready_o | output | 1 | 1 when idle and results valid |
| zero_o | output | 1 | Data word was zero, nothing programmed |
| corr_o | output | 1 | Exactly one bit mismatched on read-back |
| uncorr_o | output | 1 | Two or more bits mismatched on read-back |
| mem_addr_o | output | 13 | Array location being pulsed or read |
| mem_bit_o | output | 6 | Bit index being pulsed |
| mem_pgm_o | output | 1 | Programming pulse active |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 64 | Read-back word, valid the cycle after the strobe |

## Verification
The hardest situation to reach is a retry that actually repairs cells: the failure record must name bits that a second pulse can fix, and must exclude bits that no pulse can ever fix. The bench array model therefore has three kinds of faulty cell. Weak cells ignore their first full pulse and take the second. Cells stuck at 0 never program. Cells stuck at 1 read as 1 regardless of data. Sequences of first attempt, retry and a further retry at the same location show the pulse set shrinking to exactly the recorded failures and the grade moving from uncorrectable to clean. They also show a stuck-at-1 mismatch producing a retry with no pulses at all.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SCAN  = 3'd1,
    ST_PULSE = 3'd2,
    ST_READ  = 3'd3,
    ST_CHECK = 3'd4
  } prog_state_e;

endpackage

// File: rtl/otp_low_pick.sv
// Lowest-set-bit finder over the pending-pulse mask.
module otp_low_pick #(
  parameter int W     = 64,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);

  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_pulse_timer.sv
// Down-counter setting the length of one programming pulse.
module otp_pulse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/otp_fail_grade.sv
// Grades a mismatch mask as single-bit or multi-bit.
module otp_fail_grade #(
  parameter int W = 64
) (
  input  logic [W-1:0] fail_i,
  output logic         one_o,
  output logic         many_o
);

  logic [1:0] sat_cnt;

  always_comb begin
    sat_cnt = 2'd0;
    for (int i = 0; i < W; i++) begin
      if (fail_i[i] && (sat_cnt != 2'd2)) begin
        sat_cnt = sat_cnt + 2'd1;
      end
    end
  end

  assign one_o  = (sat_cnt == 2'd1);
  assign many_o = (sat_cnt == 2'd2);

endmodule

// File: rtl/otp_word_prog.sv
module otp_word_prog
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int HALF_W = 32,
  parameter int PW_W   = 8,
  localparam int DATA_W = 2 * HALF_W,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] data_lo_i,
  input  logic [HALF_W-1:0] data_hi_i,
  input  logic              start_i,
  input  logic              retry_i,
  input  logic [PW_W-1:0]   pulse_cnt_i,
  output logic              ready_o,
  output logic              zero_o,
  output logic              corr_o,
  output logic              uncorr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  mem_bit_o,
  output logic              mem_pgm_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  prog_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] target_q, target_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] fail_q, fail_d;
  logic [PW_W-1:0]   pw_q, pw_d;
  logic [IDX_W-1:0]  cur_idx_q, cur_idx_d;
  logic              retry_q, retry_d;
  logic              have_q, have_d;
  logic              zero_q, zero_d;
  logic              corr_q, corr_d;
  logic              unc_q, unc_d;

  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] rb_fail;
  logic              accept;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_found;
  logic              tmr_load;
  logic              tmr_done;
  logic              grade_one;
  logic              grade_many;

  assign in_word = {data_hi_i, data_lo_i};
  assign accept  = (state_q == ST_IDLE) && start_i && !(retry_i && !have_q);
  assign rb_fail = target_q ^ mem_rdata_i;

  otp_low_pick #(.W(DATA_W), .IDX_W(IDX_W)) u_pick (
    .pend_i  (pend_q),
    .idx_o   (pick_idx),
    .found_o (pick_found)
  );

  assign tmr_load = (state_q == ST_SCAN) && pick_found;

  otp_pulse_timer #(.CNT_W(PW_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (pw_q),
    .en_i       (state_q == ST_PULSE),
    .done_o     (tmr_done)
  );

  otp_fail_grade #(.W(DATA_W)) u_grade (
    .fail_i (rb_fail),
    .one_o  (grade_one),
    .many_o (grade_many)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    target_d  = target_q;
    pend_d    = pend_q;
    fail_d    = fail_q;
    pw_d      = pw_q;
    cur_idx_d = cur_idx_q;
    retry_d   = retry_q;
    have_d    = have_q;
    zero_d    = zero_q;
    corr_d    = corr_q;
    unc_d     = unc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d   = addr_i;
          target_d = in_word;
          pend_d   = retry_i ? (fail_q & in_word) : in_word;
          pw_d     = pulse_cnt_i;
          retry_d  = retry_i;
          zero_d   = 1'b0;
          corr_d   = 1'b0;
          unc_d    = 1'b0;
          state_d  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (pick_found) begin
          cur_idx_d = pick_idx;
          state_d   = ST_PULSE;
        end else if (!retry_q && (target_q == '0)) begin
          zero_d  = 1'b1;
          fail_d  = '0;
          have_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_PULSE: begin
        if (tmr_done) begin
          pend_d[cur_idx_q] = 1'b0;
          state_d           = ST_SCAN;
        end
      end
      ST_READ: begin
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        fail_d  = rb_fail;
        corr_d  = grade_one;
        unc_d   = grade_many;
        have_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      target_q  <= '0;
      pend_q    <= '0;
      fail_q    <= '0;
      pw_q      <= '0;
      cur_idx_q <= '0;
      retry_q   <= 1'b0;
      have_q    <= 1'b0;
      zero_q    <= 1'b0;
      corr_q    <= 1'b0;
      unc_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      target_q  <= target_d;
      pend_q    <= pend_d;
      fail_q    <= fail_d;
      pw_q      <= pw_d;
      cur_idx_q <= cur_idx_d;
      retry_q   <= retry_d;
      have_q    <= have_d;
      zero_q    <= zero_d;
      corr_q    <= corr_d;
      unc_q     <= unc_d;
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign zero_o     = zero_q;
  assign corr_o     = corr_q;
  assign uncorr_o   = unc_q;
  assign mem_addr_o = addr_q;
  assign mem_bit_o  = cur_idx_q;
  assign mem_pgm_o  = (state_q == ST_PULSE);
  assign mem_rd_o   = (state_q == ST_READ);

  // Assertions
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o && !(retry_i && !have_q)) |=> !ready_o);

  p_pick_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> pend_q[pick_idx]);

  p_retry_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pgm_o |-> target_q[mem_bit_o]);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zero_o, corr_o, uncorr_o}));

  p_array_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pgm_o || mem_rd_o) |-> !ready_o);

  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pgm_o && !tmr_done) |=> (mem_pgm_o && $stable(mem_bit_o) && $stable(mem_addr_o)));

  p_read_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  p_ignore_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o && retry_i && !have_q) |=>
      (ready_o && $stable({zero_o, corr_o, uncorr_o})));

endmodule

// File: tb/otp_word_prog_tb_top.sv
module otp_word_prog_tb_top;

  logic        clk;
  logic        rst_n;
  logic [12:0] addr;
  logic [31:0] dlo, dhi;
  logic        start, retry;
  logic [7:0]  pcnt;
  logic        ready, zflag, cflag, uflag;
  logic [12:0] maddr;
  logic [5:0]  mbit;
  logic        mpgm, mrd;
  logic [63:0] mrdata;

  int n_chk  = 0;
  int n_fail = 0;

  otp_word_prog dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr),
    .data_lo_i   (dlo),
    .data_hi_i   (dhi),
    .start_i     (start),
    .retry_i     (retry),
    .pulse_cnt_i (pcnt),
    .ready_o     (ready),
    .zero_o      (zflag),
    .corr_o      (cflag),
    .uncorr_o    (uflag),
    .mem_addr_o  (maddr),
    .mem_bit_o   (mbit),
    .mem_pgm_o   (mpgm),
    .mem_rd_o    (mrd),
    .mem_rdata_i (mrdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural fuse array with fault injection
  logic [63:0] arr [logic [12:0]];
  logic [63:0] stuck0_m, stuck1_m, weak_m, weak_seen;
  int          cur_pw;

  function automatic logic [63:0] arr_rd(input logic [12:0] a);
    if (arr.exists(a)) return arr[a];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (mrd) mrdata <= arr_rd(maddr) | stuck1_m;
  end

  // Scoreboard queues: pulse items {addr,bit,len}, result items {z,c,u}
  logic [27:0] exp_pulse [$];
  logic [2:0]  exp_res   [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor
  int          run_len = 0;
  logic [5:0]  run_bit;
  logic [12:0] run_addr;
  logic        ready_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mpgm) begin
        if (run_len == 0) begin
          run_bit  = mbit;
          run_addr = maddr;
        end else begin
          chk(mbit == run_bit && maddr == run_addr, "R7", "pulse target moved",
              {51'd0, maddr, mbit}, {51'd0, run_addr, run_bit});
        end
        run_len++;
      end else if (run_len > 0) begin
        if (exp_pulse.size() == 0) begin
          chk(1'b0, "R3", "unexpected pulse", {36'd0, run_addr, run_bit, 9'(run_len)}, 64'd0);
        end else begin
          logic [27:0] e;
          e = exp_pulse.pop_front();
          chk(e == {run_addr, run_bit, 9'(run_len)}, "R2 R7", "pulse addr/bit/len",
              {36'd0, run_addr, run_bit, 9'(run_len)}, {36'd0, e});
        end
        if (run_len >= cur_pw + 1 && !stuck0_m[run_bit]) begin
          if (weak_m[run_bit] && !weak_seen[run_bit]) begin
            weak_seen[run_bit] = 1'b1;
          end else begin
            logic [63:0] w;
            w = arr_rd(run_addr);
            w[run_bit] = 1'b1;
            arr[run_addr] = w;
          end
        end
        run_len = 0;
      end
      if (ready && !ready_prev) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R6", "unexpected completion", 64'd0, 64'd0);
        end else begin
          logic [2:0] r;
          r = exp_res.pop_front();
          chk({zflag, cflag, uflag} == r, "R4 R5 R8", "result flags z/c/u",
              {61'd0, zflag, cflag, uflag}, {61'd0, r});
        end
      end
      ready_prev = ready;
    end
  end

  // Driver
  task automatic run_prog(input logic [12:0] a, input logic [63:0] d, input bit rt,
                          input int pw, input logic [63:0] pulse_mask,
                          input logic [2:0] res);
    cur_pw = pw;
    for (int i = 0; i < 64; i++) begin
      if (pulse_mask[i]) exp_pulse.push_back({a, 6'(i), 9'(pw + 1)});
    end
    exp_res.push_back(res);
    @(negedge clk);
    addr = a; dlo = d[31:0]; dhi = d[63:32]; retry = rt; pcnt = 8'(pw); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ready, "R1", "busy after accepted start", {63'd0, ready}, 64'd0);
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; retry = 1'b0; addr = '0; dlo = '0; dhi = '0;
    pcnt = '0; mrdata = '0; cur_pw = 0;
    stuck0_m = '0; stuck1_m = '0; weak_m = '0; weak_seen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R10", "ready after reset", {63'd0, ready}, 64'd1);
    chk({zflag, cflag, uflag} == 3'b000, "R10", "flags after reset",
        {61'd0, zflag, cflag, uflag}, 64'd0);
    chk(!mpgm && !mrd, "R10", "array idle after reset", {62'd0, mpgm, mrd}, 64'd0);

    // R9: retry with no earlier attempt is ignored
    addr = 13'd9; dlo = 32'hF; dhi = '0; retry = 1'b1; pcnt = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; retry = 1'b0;
    chk(ready == 1'b1, "R9", "ignored retry keeps ready", {63'd0, ready}, 64'd1);
    repeat (4) @(negedge clk);
    chk(ready && {zflag, cflag, uflag} == 3'b000, "R9", "ignored retry flags/ready",
        {60'd0, ready, zflag, cflag, uflag}, 64'h8);

    // R4: zero word
    run_prog(13'd1, 64'd0, 1'b0, 2, 64'd0, 3'b100);

    // R2: clean word across both halves, bits 0,1,4,32,63
    run_prog(13'd2, 64'h8000_0001_0000_0013, 1'b0, 3,
             64'h8000_0001_0000_0013, 3'b000);

    // R5: one stuck-at-0 bit -> correctable, pulse length 1 (count 0)
    stuck0_m = 64'h10;
    run_prog(13'd3, 64'h30, 1'b0, 0, 64'h30, 3'b010);
    stuck0_m = '0;

    // R5 / R3: two stuck-at-0 bits -> uncorrectable, retry pulses only them
    stuck0_m = 64'h0000_0002_0000_0080;
    run_prog(13'd4, 64'h0000_0002_0000_0081, 1'b0, 1, 64'h0000_0002_0000_0081, 3'b001);
    run_prog(13'd4, 64'h0000_0002_0000_0081, 1'b1, 1, 64'h0000_0002_0000_0080, 3'b001);
    stuck0_m = '0;

    // R3: weak bits fail first, retry repairs, further retry has nothing to pulse
    weak_m = 64'h0000_0100_0000_0400; weak_seen = '0;
    run_prog(13'd5, 64'h0000_0100_0000_0401, 1'b0, 4, 64'h0000_0100_0000_0401, 3'b001);
    run_prog(13'd5, 64'h0000_0100_0000_0401, 1'b1, 4, 64'h0000_0100_0000_0400, 3'b000);
    run_prog(13'd5, 64'h0000_0100_0000_0401, 1'b1, 4, 64'd0, 3'b000);
    weak_m = '0;

    // R5 / R3: stuck-at-1 on a 0 data bit -> correctable, retry issues no pulse
    stuck1_m = 64'h0010_0000;
    run_prog(13'd6, 64'h1, 1'b0, 2, 64'h1, 3'b010);
    run_prog(13'd6, 64'h1, 1'b1, 2, 64'd0, 3'b010);
    stuck1_m = '0;

    repeat (3) @(negedge clk);
    chk(exp_pulse.size() == 0, "R2", "all expected pulses seen",
        64'(exp_pulse.size()), 64'd0);
    chk(exp_res.size() == 0, "R6", "all expected completions seen",
        64'(exp_res.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule